// File: doc/BRIEF.md
# Demultiplexing Sample Output Stage

This block sits between a converter core that produces one sample per input clock and the pins that carry those samples off the chip. It offers two output ports of equal width and a derived output clock that a downstream device uses to capture the ports. The output mode is chosen by a select input, which is taken in only while the divider reset is held low.

In split mode, samples are paired. The older sample of each pair goes to port B and the newer one to port A. Both ports change on the same input clock edge, once every two input clocks. The output clock is the input clock divided by two. Its rising edge falls midway between port updates, which leaves one full input period of setup and of hold.

In straight mode, every sample goes to port A at the full clock rate. Port B keeps its value, and the output clock is the inverted input clock. The active-low divider reset puts the divide-by-two phase into a known state. Several units released from the same reset therefore place the same samples on the same ports.

Top module: `dmx_out_stage`

## Requirements
- R1: With `mode_sel` high during reset (split mode, encoding 1), samples taken after reset release form pairs in order of arrival. The first sample of each pair appears on `port_b` and the second on `port_a`, and both ports change on the same rising edge of `clk`.
- R2: In split mode, the ports change only on every second rising edge of `clk` after release. On the edges between, both ports hold their values.
- R3: In split mode, `clk_out` is low while reset is held. After the m-th rising edge following release (m counted from 0), `clk_out` equals m modulo 2. It therefore falls on the edge that updates the ports and rises one input clock later.
- R4: With `mode_sel` low during reset (straight mode, encoding 0), a sample presented at rising edge m after release appears on `port_a` right after edge m+1.
- R5: In straight mode, `clk_out` is the logical inverse of `clk`.
- R6: In straight mode, `port_b` does not change after release and keeps the value 0 that reset gave it.
- R7: The divider reset `div_rst_n` is active low and sampled on rising edges of `clk`. While it is low, both ports read 0 and the pair phase is cleared. After release, pairing starts fresh with the first sample, whatever the phase was before the reset.
- R8: `mode_sel` is sampled only while `div_rst_n` is low. Changing it while reset is high has no effect on the ports or on `clk_out`.
- R9: In split mode, the newer sample of a pair (presented at edge m, with m odd) appears on `port_a` right after edge m+1, the same two-edge latency as straight mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock from the converter core |
| div_rst_n | input | 1 | Active-low synchronous divider reset; also latches the mode |
| mode_sel | input | 1 | 1 = split (two-port) mode, 0 = straight mode; sampled during reset |
| sample_in | input | W | One sample per rising edge of clk |
| port_a | output | W | Newer sample of a pair (split) or every sample (straight) |
| port_b | output | W | Older sample of a pair (split); held in straight mode |
| clk_out | output | 1 | Half-rate capture clock (split) or inverted clk (straight) |

## Verification
A pair phase that is off by one shows as swapped port contents on the first pair update, two edges after release. It also shows as an inverted `clk_out` from the second edge on. A mode register that follows `mode_sel` outside reset shows within one edge: `port_b` starts moving, or `clk_out` stops toggling at half rate. A missing or extra pipeline stage offsets every sample on `port_a` by one position, which the first few samples after each reset expose. A reset given in the middle of a pair must restart the pairing, and that is visible on the very next pair update.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  typedef enum logic {
    MODE_STRAIGHT = 1'b0,
    MODE_SPLIT    = 1'b1
  } out_mode_e;

  // Slot value after one edge: a valid sample flips the pair slot.
  function automatic logic slot_after(input logic slot, input logic vld);
    return vld ? ~slot : slot;
  endfunction

  // True when the sample now in the capture stage completes an output word.
  function automatic logic word_closes(input out_mode_e m, input logic slot,
                                       input logic vld);
    return vld && ((m == MODE_STRAIGHT) || slot);
  endfunction

  // True when the capture stage holds the older half of a pair.
  function automatic logic pair_opens(input out_mode_e m, input logic slot,
                                      input logic vld);
    return vld && (m == MODE_SPLIT) && !slot;
  endfunction

endpackage

// File: rtl/dmx_capture.sv
module dmx_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dq,
  output logic         dvld
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq   <= '0;
      dvld <= 1'b0;
    end else begin
      dq   <= din;
      dvld <= 1'b1;
    end
  end

  // R7: the capture stage is valid from the first edge after release
  a_r7_valid_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> dvld);

endmodule

// File: rtl/dmx_phase.sv
module dmx_phase
  import dmx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel,
  input  logic      dvld,
  output out_mode_e mode,
  output logic      slot
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= out_mode_e'(sel);
      slot <= 1'b0;
    end else if (mode == MODE_SPLIT) begin
      slot <= slot_after(slot, dvld);
    end else begin
      slot <= 1'b0;
    end
  end

  // R8: the mode does not move while reset is released
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode));

  // R3: in split mode the phase flips on every valid sample
  a_r3_slot_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SPLIT && dvld) |=> (slot != $past(slot)));

endmodule

// File: rtl/dmx_steer.sv
module dmx_steer
  import dmx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  out_mode_e    mode,
  input  logic         slot,
  input  logic [W-1:0] dq,
  input  logic         dvld,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b
);

  logic [W-1:0] hold_q;
  logic         load_word;
  logic         stash_old;

  assign load_word = word_closes(mode, slot, dvld);
  assign stash_old = pair_opens(mode, slot, dvld);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      port_a <= '0;
      port_b <= '0;
    end else begin
      if (stash_old) hold_q <= dq;
      if (load_word) begin
        port_a <= dq;
        if (mode == MODE_SPLIT) port_b <= hold_q;
      end
    end
  end

  // R2: between pair updates both ports hold
  a_r2_ports_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SPLIT && !(dvld && slot)) |=> ($stable(port_a) && $stable(port_b)));

  // R1: port_b receives the sample captured one edge before the newer one
  a_r1_older_on_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SPLIT && dvld && slot && $past(dvld)) |=> (port_b == $past(dq, 2)));

  // R4: straight mode passes every captured sample to port_a
  a_r4_straight_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STRAIGHT && dvld) |=> (port_a == $past(dq)));

  // R6: port_b is frozen in straight mode
  a_r6_b_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STRAIGHT && $past(rst_n)) |-> $stable(port_b));

endmodule

// File: rtl/dmx_out_stage.sv
module dmx_out_stage
  import dmx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         div_rst_n,
  input  logic         mode_sel,
  input  logic [W-1:0] sample_in,
  output logic [W-1:0] port_a,
  output logic [W-1:0] port_b,
  output logic         clk_out
);

  logic [W-1:0] cap_q;
  logic         cap_vld;
  out_mode_e    mode;
  logic         slot;

  dmx_capture #(.W(W)) u_cap (
    .clk  (clk),
    .rst_n(div_rst_n),
    .din  (sample_in),
    .dq   (cap_q),
    .dvld (cap_vld)
  );

  dmx_phase u_phase (
    .clk  (clk),
    .rst_n(div_rst_n),
    .sel  (mode_sel),
    .dvld (cap_vld),
    .mode (mode),
    .slot (slot)
  );

  dmx_steer #(.W(W)) u_steer (
    .clk   (clk),
    .rst_n (div_rst_n),
    .mode  (mode),
    .slot  (slot),
    .dq    (cap_q),
    .dvld  (cap_vld),
    .port_a(port_a),
    .port_b(port_b)
  );

  // The pair slot register is the divided clock; straight mode inverts clk.
  always_comb begin
    if (mode == MODE_SPLIT) clk_out = slot;
    else                    clk_out = ~clk;
  end

  // R7: ports read zero on the edge after reset is sampled low
  a_r7_reset_clears: assert property (@(posedge clk)
    !$past(div_rst_n) && $past(div_rst_n, 2) |-> (port_a == '0 && port_b == '0));

endmodule

// File: tb/dmx_out_stage_test.sv
module dmx_out_stage_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         div_rst_n = 1'b0;
  logic         mode_sel = 1'b1;
  logic [W-1:0] sample_in = '0;
  logic [W-1:0] port_a, port_b;
  logic         clk_out;

  always #5 clk = ~clk;

  dmx_out_stage #(.W(W)) uut (
    .clk      (clk),
    .div_rst_n(div_rst_n),
    .mode_sel (mode_sel),
    .sample_in(sample_in),
    .port_a   (port_a),
    .port_b   (port_b),
    .clk_out  (clk_out)
  );

  int         checks = 0;
  int         fails = 0;
  bit         done = 0;
  logic [W-1:0] hist [0:1023];
  int         m = -1;
  bit         split_q = 1'b1;

  task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // Expected contents of the ports after edge idx in split mode
  function automatic int last_pair_edge(input int idx);
    int k;
    k = (idx % 2 == 0) ? idx : idx - 1;
    return k;
  endfunction

  // Called at a falling edge; ends at a falling edge.
  task automatic do_reset(input bit sel, input int cycles);
    div_rst_n = 1'b0;
    mode_sel  = sel;
    repeat (cycles) @(posedge clk);
    #2;
    chk("R7 port_a cleared in reset", 32'(port_a), 32'h0);
    chk("R7 port_b cleared in reset", 32'(port_b), 32'h0);
    if (sel) chk("R3 clk_out low in reset", 32'(clk_out), 32'h0);
    @(negedge clk);
    div_rst_n = 1'b1;
    split_q   = sel;
    m         = -1;
  endtask

  task automatic step(input logic [W-1:0] d, input string tag);
    int k;
    logic [W-1:0] ea, eb;
    sample_in = d;
    m++;
    hist[m] = d;
    if (!split_q) begin
      #1;
      chk({tag, " R5 clk_out high while clk low"}, 32'(clk_out), 32'h1);
    end
    @(posedge clk);
    #2;
    if (split_q) begin
      k = last_pair_edge(m);
      ea = (k >= 2) ? hist[k-1] : '0;
      eb = (k >= 2) ? hist[k-2] : '0;
      chk({tag, (m % 2 == 1) ? " R2 port_a held" : " R9 port_a newer"}, 32'(port_a), 32'(ea));
      chk({tag, (m % 2 == 1) ? " R2 port_b held" : " R1 port_b older"}, 32'(port_b), 32'(eb));
      chk({tag, " R3 divided clk_out"}, 32'(clk_out), 32'(m % 2));
    end else begin
      ea = (m >= 1) ? hist[m-1] : '0;
      chk({tag, " R4 port_a latency"}, 32'(port_a), 32'(ea));
      chk({tag, " R6 port_b frozen"}, 32'(port_b), 32'h0);
      chk({tag, " R5 clk_out low while clk high"}, 32'(clk_out), 32'h0);
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R1 R2 R3 R9: split mode, directed then random
    do_reset(1'b1, 2);
    step(8'h00, "R1");
    step(8'hFF, "R1");
    step(8'hA5, "R1");
    step(8'h5A, "R1");
    for (int i = 0; i < 40; i++) step(W'($urandom), "R9");

    // R8: mode_sel changes while reset released have no effect
    mode_sel = 1'b0;
    for (int i = 0; i < 15; i++) step(W'($urandom), "R8 split");

    // R7: reset in the middle of a pair restarts the pairing
    step(8'h3C, "R7");
    do_reset(1'b1, 3);
    for (int i = 0; i < 12; i++) step(W'($urandom), "R7 realign");

    // R4 R5 R6: straight mode
    do_reset(1'b0, 2);
    step(8'hFF, "R4");
    step(8'h00, "R4");
    step(8'h81, "R4");
    for (int i = 0; i < 40; i++) step(W'($urandom), "R4");

    // R8: raising mode_sel in straight mode has no effect
    mode_sel = 1'b1;
    for (int i = 0; i < 15; i++) step(W'($urandom), "R8 straight");

    // Back to split mode with a fresh reset
    do_reset(1'b1, 2);
    for (int i = 0; i < 20; i++) step(W'($urandom), "R1 resume");

    finish_run();
  end

endmodule